// File: doc/BRIEF.md
# Single-Clock FIFO with Port Stall Controls

This block is a first-in first-out buffer that runs on one rising-edge clock. Words enter through an active-high write enable with a data bus and leave through an active-high read enable. The read word is registered, so it appears one clock after the read is taken. Storage is an inferred two-port memory array. Its depth and word width are parameters.

The block reports registered overflow and underflow flags and full and empty status. It also gives two occupancy counts: the number of words held and the number of free slots. Their sum is always the depth. Each port has a stall input. A mode parameter chooses what the stall does. The read stall can be ignored, can freeze the pop and the underflow check, or can also freeze the memory read so that the output word holds. The write stall can be ignored, can cancel the write in the same cycle, or can cancel the write one cycle later. The reset is active low and synchronous to the clock.

Top module: `sync_fifo_stall`

## Requirements
- R1: While the synchronous active-low reset is low, and in the cycle after it, `used_words` is 0, `free_words` equals DEPTH, `empty` is 1, and `full`, `overflow` and `underflow` are 0.
- R2: Words leave in the order they were accepted. When a read is accepted at a rising edge, that word is on `rd_data` after the same edge. This holds across pointer wrap-around.
- R3: A write attempted while `full` is 1 (and not stalled) is discarded. The stored contents and counts are unchanged, and `overflow` is 1 for exactly the cycle that follows the attempt.
- R4: A read attempted while `empty` is 1 (and not stalled) changes nothing, and `underflow` is 1 for exactly the cycle that follows the attempt.
- R5: `used_words` goes up by one per accepted write and down by one per accepted read. `free_words` always equals DEPTH minus `used_words`.
- R6: `full` is 1 exactly when `used_words` equals DEPTH, and `empty` is 1 exactly when `used_words` is 0.
- R7: A read and a write in the same cycle, while the buffer is neither empty nor full, leave `used_words` unchanged. Both operations still take effect.
- R8: With RD_STALL_MODE 0, `rd_stall` has no effect: a stalled read still pops the head word, and a stalled read of an empty buffer still raises `underflow`.
- R9: With RD_STALL_MODE 1, a read with `rd_stall` high does not pop and raises no underflow. The memory read still happens, so `rd_data` shows the current head word.
- R10: With RD_STALL_MODE 2, a read with `rd_stall` high does not pop and raises no underflow, and `rd_data` keeps its previous value.
- R11: With WR_STALL_MODE 1, a write presented in a cycle where `wr_stall` is high is not stored.
- R12: With WR_STALL_MODE 2, a write is not stored if `wr_stall` was high in the previous cycle. `wr_stall` has no effect on the write in its own cycle.
- R13: With WR_STALL_MODE 0, `wr_stall` has no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_en | input | 1 | Write request, active high |
| wr_data | input | WIDTH | Word to store |
| wr_stall | input | 1 | Write stall, meaning set by WR_STALL_MODE |
| rd_en | input | 1 | Read request, active high |
| rd_stall | input | 1 | Read stall, meaning set by RD_STALL_MODE |
| rd_data | output | WIDTH | Registered word from the last read |
| overflow | output | 1 | One-cycle pulse after a write to a full buffer |
| underflow | output | 1 | One-cycle pulse after a read of an empty buffer |
| used_words | output | $clog2(DEPTH+1) | Number of words held |
| free_words | output | $clog2(DEPTH+1) | Number of free slots |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |

## Verification
Every result is registered. Counts, status, error pulses and read data therefore change at the rising edge that samples the request. The bench drives requests on falling edges and compares outputs on the next falling edge. Each check sits half a cycle after the edge that should produce its result. The next-cycle write stall is checked by placing the stall one falling edge before the write it cancels, and then looking one edge after that write. Three instances with different stall modes receive the same stimulus. Each scenario states what each instance should show at each sample point.

// File: rtl/sync_fifo_stall.sv
module sync_fifo_stall #(
  parameter int WIDTH         = 8,
  parameter int DEPTH         = 16,
  parameter int RD_STALL_MODE = 2,
  parameter int WR_STALL_MODE = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_stall,
  input  logic             rd_en,
  input  logic             rd_stall,
  output logic [WIDTH-1:0] rd_data,
  output logic             overflow,
  output logic             underflow,
  output logic [CW-1:0]    used_words,
  output logic [CW-1:0]    free_words,
  output logic             full,
  output logic             empty
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [1:0]    WMODE = WR_STALL_MODE[1:0];
  localparam logic [1:0]    RMODE = RD_STALL_MODE[1:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    used_q;
  logic             stall_q;
  logic             wr_block, rd_freeze, rd_hold;
  logic             wr_go, rd_go, rd_port;

  assign full       = (used_q == CW'(DEPTH));
  assign empty      = (used_q == '0);
  assign used_words = used_q;
  assign free_words = CW'(DEPTH) - used_q;

  assign wr_block  = ((WMODE == 2'd1) & wr_stall) | ((WMODE == 2'd2) & stall_q);
  assign rd_freeze = (RMODE != 2'd0) & rd_stall;
  assign rd_hold   = (RMODE == 2'd2) & rd_stall;

  assign wr_go   = wr_en & ~full & ~wr_block;
  assign rd_go   = rd_en & ~empty & ~rd_freeze;
  assign rd_port = rd_en & ~empty & ~rd_hold;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      used_q    <= '0;
      stall_q   <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      rd_data   <= '0;
    end else begin
      stall_q   <= wr_stall;
      overflow  <= wr_en & full & ~wr_block;
      underflow <= rd_en & empty & ~rd_freeze;
      if (rd_port) rd_data <= mem[rd_ptr];
      if (wr_go) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (rd_go) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({wr_go, rd_go})
        2'b10:   used_q <= used_q + CW'(1);
        2'b01:   used_q <= used_q - CW'(1);
        default: used_q <= used_q;
      endcase
    end
  end

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(full && wr_en));
  p_full_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> (full && $stable(wr_ptr)));
  p_unf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(empty && rd_en));
  p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !rd_go) |=> (used_q == $past(used_q) + CW'(1)));
  p_both_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |=> $stable(used_q));

  generate
    if (RD_STALL_MODE == 2) begin : g_rd_hold_chk
      p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |=> ($stable(rd_data) && $stable(rd_ptr)));
    end else if (RD_STALL_MODE == 1) begin : g_rd_frz_chk
      p_rd_frz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |=> ($stable(rd_ptr) && !underflow));
    end
    if (WR_STALL_MODE == 1) begin : g_wr_now_chk
      p_wr_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !rd_en) |=> $stable(used_q));
    end else if (WR_STALL_MODE == 2) begin : g_wr_next_chk
      p_wr_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall ##1 !rd_en |=> $stable(used_q));
    end
  endgenerate

endmodule

// File: tb/sync_fifo_stall_tb.sv
`timescale 1ns/1ps
module sync_fifo_stall_tb_top;
  localparam int W  = 8;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_stall = 0, rd_en = 0, rd_stall = 0;
  logic [W-1:0] wr_data = '0;

  logic [W-1:0]  a_rd, b_rd, c_rd;
  logic          a_ov, b_ov, c_ov, a_un, b_un, c_un;
  logic [CW-1:0] a_us, b_us, c_us, a_fr, b_fr, c_fr;
  logic          a_fu, b_fu, c_fu, a_em, b_em, c_em;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_fifo_stall #(.WIDTH(W), .DEPTH(D), .RD_STALL_MODE(2), .WR_STALL_MODE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_en(rd_en), .rd_stall(rd_stall), .rd_data(a_rd), .overflow(a_ov), .underflow(a_un),
    .used_words(a_us), .free_words(a_fr), .full(a_fu), .empty(a_em));
  sync_fifo_stall #(.WIDTH(W), .DEPTH(D), .RD_STALL_MODE(1), .WR_STALL_MODE(2)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_en(rd_en), .rd_stall(rd_stall), .rd_data(b_rd), .overflow(b_ov), .underflow(b_un),
    .used_words(b_us), .free_words(b_fr), .full(b_fu), .empty(b_em));
  sync_fifo_stall #(.WIDTH(W), .DEPTH(D), .RD_STALL_MODE(0), .WR_STALL_MODE(0)) dut_c (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_en(rd_en), .rd_stall(rd_stall), .rd_data(c_rd), .overflow(c_ov), .underflow(c_un),
    .used_words(c_us), .free_words(c_fr), .full(c_fu), .empty(c_em));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, bit [W-1:0] wd, bit ws, bit re, bit rs);
    wr_en = we; wr_data = wd; wr_stall = ws; rd_en = re; rd_stall = rs;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_stall = 0; rd_en = 0; rd_stall = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 used during reset", a_us, 0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 used", a_us, 0);
    chk("R1 free", a_fr, D);
    chk("R1 empty", a_em, 1);
    chk("R1 full", a_fu, 0);
    chk("R1 ovf/unf", {a_ov, a_un, c_ov, c_un}, 0);
  endtask

  task automatic t_fill_drain();
    do_reset();
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < D; i++) begin
        cyc(1, W'(8'h10 + 16*pass + i), 0, 0, 0);
        chk("R5 used on fill", a_us, i + 1);
        chk("R5 free on fill", a_fr, D - i - 1);
      end
      chk("R6 full", a_fu, 1);
      chk("R6 not empty", a_em, 0);
      cyc(1, 8'h99, 0, 0, 0);
      chk("R3 overflow pulse", a_ov, 1);
      chk("R3 used unchanged", a_us, D);
      cyc(0, 0, 0, 0, 0);
      chk("R3 overflow clears", a_ov, 0);
      for (int i = 0; i < D; i++) begin
        cyc(0, 0, 0, 1, 0);
        chk("R2 order/data", a_rd, 8'h10 + 16*pass + i);
        chk("R2 order/data c", c_rd, 8'h10 + 16*pass + i);
      end
      chk("R6 empty", a_em, 1);
      cyc(0, 0, 0, 1, 0);
      chk("R4 underflow pulse", a_un, 1);
      chk("R4 used stays", a_us, 0);
      chk("R4 data stays", a_rd, 8'h13 + 16*pass);
      cyc(0, 0, 0, 0, 0);
      chk("R4 underflow clears", a_un, 0);
    end
  endtask

  task automatic t_both();
    do_reset();
    cyc(1, 8'h41, 0, 0, 0);
    cyc(1, 8'h42, 0, 0, 0);
    cyc(1, 8'h43, 0, 1, 0);
    chk("R7 used flat", a_us, 2);
    chk("R7 read data", a_rd, 8'h41);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7 write kept", a_rd, 8'h43);
  endtask

  task automatic t_rd_stall();
    do_reset();
    cyc(1, 8'hA1, 0, 0, 0);
    cyc(1, 8'hB2, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R10 data held", a_rd, 8'hA1);
    chk("R10 no pop", a_us, 1);
    chk("R9 head shown", b_rd, 8'hB2);
    chk("R9 no pop", b_us, 1);
    chk("R8 popped", c_rd, 8'hB2);
    chk("R8 count", c_us, 0);
    do_reset();
    cyc(0, 0, 0, 1, 1);
    chk("R10 no underflow", a_un, 0);
    chk("R9 no underflow", b_un, 0);
    chk("R8 underflow", c_un, 1);
  endtask

  task automatic t_wr_stall();
    do_reset();
    cyc(1, 8'h31, 1, 0, 0);
    chk("R11 blocked now", a_us, 0);
    chk("R12 not blocked now", b_us, 1);
    chk("R13 ignored", c_us, 1);
    cyc(1, 8'h32, 0, 0, 0);
    chk("R11 next accepted", a_us, 1);
    chk("R12 blocked next", b_us, 1);
    chk("R13 second write", c_us, 2);
    cyc(0, 0, 0, 1, 0);
    chk("R11 stored word", a_rd, 8'h32);
    chk("R12 stored word", b_rd, 8'h31);
    chk("R13 stored word", c_rd, 8'h31);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_both();
    t_rd_stall();
    t_wr_stall();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule